// File: doc/BRIEF.md
# Floppy Drive Control and Status Register

This block is a byte-wide register at a single I/O port number. It sits between a processor I/O bus and a floppy disk controller with its drives. A write to the port stores the drive selection, the head side, the recording density, the drive size and an auto-wait enable. These values drive the controller and drive pins directly. A read from the port returns a status byte. That byte combines the controller's live handshake lines, two board-level straps, the motor state and two timeout flags.

The block holds two tick-driven timers. The motor timer starts when a disk command begins. If 128 timeout ticks pass with no new command, the motor turns off, the head side returns to side 0 and a sticky flag records the event. The auto-wait timer runs while auto-wait is enabled. It sets a sticky flag when neither a data request nor an interrupt request arrives within a programmable number of ticks. Both flags clear on the next control write.

Top module: `fdc_ctlstat`

## Requirements
- R1: After reset the outputs are drive 0, side 0, single density, 8-inch, auto-wait off and motor off. Both timeout flags are clear and `io_rdata` is 0.
- R2: A write pulse with `io_addr == PORT_ADDR` updates the controls from `io_wdata` on the next cycle. Bits 1:0 set the drive number. Bit 2 selects side 1 when set. Bit 3 selects double density when set. Bit 4 selects a 5.25-inch drive when set and an 8-inch drive when clear. Bit 7 enables auto-wait. Bits 5 and 6 have no effect.
- R3: A write pulse to any other port number leaves every control output unchanged.
- R4: A read pulse at `PORT_ADDR` puts the status byte on `io_rdata` in the next cycle. The bits are: bit 7 data request, bit 6 boot strap (raw active-low level), bit 5 head load, bit 4 inhibit-init (raw active-low level), bit 3 motor on, bit 2 motor timeout flag, bit 1 auto-wait timeout flag, bit 0 controller interrupt request. In every other cycle `io_rdata` is 0.
- R5: A `cmd_start` pulse sets motor-on and restarts the motor timeout count.
- R6: On the 128th tick after the last `cmd_start`, the block clears motor-on and the side select and sets the motor timeout flag. Drive, density, size and auto-wait stay unchanged.
- R7: A control write at `PORT_ADDR` clears both the motor timeout flag and the auto-wait timeout flag.
- R8: With auto-wait enabled, the auto-wait flag sets on the `aw_limit`-th tick that arrives while neither `fdc_drq` nor `fdc_intrq` is high. Either request line restarts the count. With auto-wait disabled, the flag never sets.
- R9: Ticks that arrive while the motor is off change neither the motor state nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port number |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid the cycle after a hitting read |
| tick | input | 1 | Timeout tick pulse |
| cmd_start | input | 1 | Pulse when a disk command is started |
| aw_limit | input | AW_W | Auto-wait timeout in ticks |
| fdc_drq | input | 1 | Controller data request |
| fdc_intrq | input | 1 | Controller interrupt request (end of job) |
| fdc_hld | input | 1 | Head load / select request from the controller |
| inhibit_init_n | input | 1 | Inhibit-init strap, active low |
| boot_strap_n | input | 1 | Boot strap, active low |
| drv_sel | output | 2 | Selected drive |
| side_sel | output | 1 | Head side, 1 = side 1 |
| dens_dbl | output | 1 | Double density select |
| mini_drv | output | 1 | 5.25-inch drive select |
| autowait_en | output | 1 | Auto-wait enable |
| motor_on | output | 1 | Drive motor on |

## Verification
A corrupted control field appears on the drive pins in the first cycle after the write. A corrupted timer count shows up later. It appears as a motor that turns off one tick early or late, or as an auto-wait flag that sets on the wrong tick. In either case it is visible only through the status byte on the read that follows. The checks therefore count ticks exactly to both timeout boundaries. They also read the flags back just before and just after each boundary, so an off-by-one error in a count shows on a single read.

// File: rtl/fdc_ctl_pkg.sv
package fdc_ctl_pkg;

    // Control byte field positions (write side)
    localparam int CB_DRV_LO = 0;
    localparam int CB_SIDE   = 2;
    localparam int CB_DENS   = 3;
    localparam int CB_MINI   = 4;
    localparam int CB_AW     = 7;

    // Status byte field positions (read side)
    localparam int SB_INTRQ  = 0;
    localparam int SB_ATO    = 1;
    localparam int SB_MTO    = 2;
    localparam int SB_MOTOR  = 3;
    localparam int SB_INH    = 4;
    localparam int SB_HLD    = 5;
    localparam int SB_BOOT   = 6;
    localparam int SB_DRQ    = 7;

    typedef struct packed {
        logic       aw_en;
        logic       mini;
        logic       dens;
        logic       side;
        logic [1:0] drv;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{aw_en: 1'b0, mini: 1'b0, dens: 1'b0, side: 1'b0, drv: 2'd0};

    function automatic ctl_t decode_ctl(input logic [7:0] b);
        ctl_t c;
        c.drv   = b[CB_DRV_LO +: 2];
        c.side  = b[CB_SIDE];
        c.dens  = b[CB_DENS];
        c.mini  = b[CB_MINI];
        c.aw_en = b[CB_AW];
        return c;
    endfunction

endpackage

// File: rtl/fdc_ctl_latch.sv
module fdc_ctl_latch
    import fdc_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    input  logic       side_clr_i,
    output ctl_t       ctl_o
);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_i) begin
            ctl_d = decode_ctl(wdata_i);
        end
        // motor timeout overrides a same-cycle write for the side bit
        if (side_clr_i) begin
            ctl_d.side = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign ctl_o = ctl_q;

    AST_WR_DRV: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ctl_o.drv == $past(wdata_i[1:0]) && ctl_o.aw_en == $past(wdata_i[7])); // R2

    AST_SIDE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        side_clr_i |=> !ctl_o.side); // R6

endmodule

// File: rtl/fdc_motor_timer.sv
module fdc_motor_timer #(
    parameter int MOTOR_TICKS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    input  logic clr_flag_i,
    output logic motor_o,
    output logic mto_o,
    output logic fire_o
);

    localparam int MW = (MOTOR_TICKS > 2) ? $clog2(MOTOR_TICKS) : 1;
    localparam logic [MW-1:0] LAST = MW'(MOTOR_TICKS - 1);

    typedef struct packed {
        logic [MW-1:0] cnt;
        logic          on;
        logic          mto;
    } mot_t;

    mot_t st_d, st_q;
    logic fire;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (clr_flag_i) begin
            st_d.mto = 1'b0;
        end
        if (start_i) begin
            st_d.on  = 1'b1;
            st_d.cnt = '0;
        end else if (tick_i && st_q.on) begin
            if (st_q.cnt == LAST) begin
                fire     = 1'b1;
                st_d.on  = 1'b0;
                st_d.cnt = '0;
                st_d.mto = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + MW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign motor_o = st_q.on;
    assign mto_o   = st_q.mto;
    assign fire_o  = fire;

    AST_MOTOR_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> motor_o); // R5

    AST_MTO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mto_o) |-> !motor_o); // R6

    AST_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!motor_o && !start_i) |=> !motor_o); // R9

endmodule

// File: rtl/fdc_wait_timer.sv
module fdc_wait_timer #(
    parameter int AW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            aw_en_i,
    input  logic            drq_i,
    input  logic            intrq_i,
    input  logic            tick_i,
    input  logic [AW_W-1:0] limit_i,
    input  logic            clr_i,
    output logic            ato_o
);

    typedef struct packed {
        logic [AW_W-1:0] cnt;
        logic            ato;
    } aw_t;

    aw_t st_d, st_q;
    logic [AW_W:0] cnt_next;

    always_comb begin
        st_d     = st_q;
        cnt_next = {1'b0, st_q.cnt} + (AW_W+1)'(1);
        if (!aw_en_i || drq_i || intrq_i) begin
            st_d.cnt = '0;
        end else if (tick_i && !st_q.ato) begin
            if (cnt_next >= {1'b0, limit_i}) begin
                st_d.ato = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_next[AW_W-1:0];
            end
        end
        if (clr_i) begin
            st_d.ato = 1'b0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ato_o = st_q.ato;

    AST_ATO_NEEDS_AW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ato_o) |-> $past(aw_en_i)); // R8

    AST_ATO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !ato_o); // R7

endmodule

// File: rtl/fdc_ctlstat.sv
module fdc_ctlstat
    import fdc_ctl_pkg::*;
#(
    parameter logic [7:0] PORT_ADDR   = 8'h3C,
    parameter int         MOTOR_TICKS = 128,
    parameter int         AW_W        = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      io_addr,
    input  logic            io_wr,
    input  logic            io_rd,
    input  logic [7:0]      io_wdata,
    output logic [7:0]      io_rdata,
    input  logic            tick,
    input  logic            cmd_start,
    input  logic [AW_W-1:0] aw_limit,
    input  logic            fdc_drq,
    input  logic            fdc_intrq,
    input  logic            fdc_hld,
    input  logic            inhibit_init_n,
    input  logic            boot_strap_n,
    output logic [1:0]      drv_sel,
    output logic            side_sel,
    output logic            dens_dbl,
    output logic            mini_drv,
    output logic            autowait_en,
    output logic            motor_on
);

    logic hit, wr_hit, rd_hit;
    logic mto_flag, ato_flag, mto_fire, motor;
    ctl_t ctl;
    logic [7:0] status;
    logic [7:0] rdata_d, rdata_q;

    assign hit    = (io_addr == PORT_ADDR);
    assign wr_hit = io_wr && hit;
    assign rd_hit = io_rd && hit;

    fdc_ctl_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_hit),
        .wdata_i    (io_wdata),
        .side_clr_i (mto_fire),
        .ctl_o      (ctl)
    );

    fdc_motor_timer #(.MOTOR_TICKS(MOTOR_TICKS)) u_motor (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (cmd_start),
        .tick_i     (tick),
        .clr_flag_i (wr_hit),
        .motor_o    (motor),
        .mto_o      (mto_flag),
        .fire_o     (mto_fire)
    );

    fdc_wait_timer #(.AW_W(AW_W)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .aw_en_i (ctl.aw_en),
        .drq_i   (fdc_drq),
        .intrq_i (fdc_intrq),
        .tick_i  (tick),
        .limit_i (aw_limit),
        .clr_i   (wr_hit),
        .ato_o   (ato_flag)
    );

    always_comb begin
        status           = '0;
        status[SB_DRQ]   = fdc_drq;
        status[SB_BOOT]  = boot_strap_n;
        status[SB_HLD]   = fdc_hld;
        status[SB_INH]   = inhibit_init_n;
        status[SB_MOTOR] = motor;
        status[SB_MTO]   = mto_flag;
        status[SB_ATO]   = ato_flag;
        status[SB_INTRQ] = fdc_intrq;
        rdata_d          = rd_hit ? status : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= 8'h00;
        else        rdata_q <= rdata_d;
    end

    assign io_rdata    = rdata_q;
    assign drv_sel     = ctl.drv;
    assign side_sel    = ctl.side;
    assign dens_dbl    = ctl.dens;
    assign mini_drv    = ctl.mini;
    assign autowait_en = ctl.aw_en;
    assign motor_on    = motor;

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> io_rdata == 8'h00); // R4

    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(drv_sel) && $stable(dens_dbl) && $stable(mini_drv) && $stable(autowait_en)); // R3

endmodule

// File: tb/fdc_ctlstat_tb_top.sv
`timescale 1ns/1ps
module fdc_ctlstat_tb_top;

    localparam logic [7:0] PA = 8'h3C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       tick = 1'b0, cmd_start = 1'b0;
    logic [7:0] aw_limit = 8'd5;
    logic       fdc_drq = 1'b0, fdc_intrq = 1'b0, fdc_hld = 1'b0;
    logic       inhibit_init_n = 1'b1, boot_strap_n = 1'b1;
    logic [1:0] drv_sel;
    logic       side_sel, dens_dbl, mini_drv, autowait_en, motor_on;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    fdc_ctlstat #(.PORT_ADDR(PA)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .tick(tick), .cmd_start(cmd_start),
        .aw_limit(aw_limit), .fdc_drq(fdc_drq), .fdc_intrq(fdc_intrq), .fdc_hld(fdc_hld),
        .inhibit_init_n(inhibit_init_n), .boot_strap_n(boot_strap_n), .drv_sel(drv_sel),
        .side_sel(side_sel), .dens_dbl(dens_dbl), .mini_drv(mini_drv),
        .autowait_en(autowait_en), .motor_on(motor_on)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ctl_vec();
        return {autowait_en, 2'b00, mini_drv, dens_dbl, side_sel, drv_sel};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic start_cmd();
        @(negedge clk); cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 controls", ctl_vec(), 8'h00);
        chk("R1 motor", {7'd0, motor_on}, 8'h00);
        chk("R1 rdata", io_rdata, 8'h00);
    endtask

    task automatic t_write();
        wr(PA, 8'hFF);
        chk("R2 all set", ctl_vec(), 8'h9F);
        wr(PA, 8'h61);
        chk("R2 bits 5,6 ignored", ctl_vec(), 8'h01);
        wr(PA, 8'h0A);
        chk("R2 dens drv2", ctl_vec(), 8'h0A);
        wr(PA, 8'h14);
        chk("R2 mini side", ctl_vec(), 8'h14);
    endtask

    task automatic t_miss();
        wr(PA + 8'd1, 8'hFF);
        chk("R3 miss write", ctl_vec(), 8'h14);
    endtask

    task automatic t_read();
        logic [7:0] v;
        fdc_drq = 1'b1; fdc_hld = 1'b1; boot_strap_n = 1'b0; inhibit_init_n = 1'b1; fdc_intrq = 1'b0;
        rd(PA, v);
        chk("R4 status A", v, 8'hB0);
        @(negedge clk);
        chk("R4 idle after read", io_rdata, 8'h00);
        fdc_drq = 1'b0; fdc_hld = 1'b0; boot_strap_n = 1'b1; inhibit_init_n = 1'b0; fdc_intrq = 1'b1;
        rd(PA, v);
        chk("R4 status B", v, 8'h41);
        rd(PA - 8'd1, v);
        chk("R4 miss read", v, 8'h00);
        fdc_intrq = 1'b0; inhibit_init_n = 1'b1;
    endtask

    task automatic t_idle_ticks();
        logic [7:0] v;
        ticks(200);
        rd(PA, v);
        chk("R9 idle ticks", v, 8'h50);
    endtask

    task automatic t_motor();
        logic [7:0] v;
        wr(PA, 8'h0D);                  // drv1, side1, dens
        start_cmd();
        chk("R5 motor on", {7'd0, motor_on}, 8'h01);
        ticks(127);
        rd(PA, v);
        chk("R6 before timeout", v, 8'h58);
        chk("R6 side kept", {7'd0, side_sel}, 8'h01);
        ticks(1);
        rd(PA, v);
        chk("R6 timeout status", v, 8'h54);
        chk("R6 controls after", ctl_vec(), 8'h09);
        wr(PA, 8'h09);
        rd(PA, v);
        chk("R7 mto cleared", v, 8'h50);
        // restart in the middle of the window
        start_cmd();
        ticks(100);
        start_cmd();
        ticks(127);
        chk("R5 restarted count", {7'd0, motor_on}, 8'h01);
        ticks(1);
        chk("R6 off after restart", {7'd0, motor_on}, 8'h00);
        wr(PA, 8'h00);
    endtask

    task automatic t_autowait();
        logic [7:0] v;
        aw_limit = 8'd5;
        wr(PA, 8'h80);
        ticks(4);
        rd(PA, v);
        chk("R8 before limit", v, 8'h50);
        @(negedge clk); fdc_drq = 1'b1;
        @(negedge clk); fdc_drq = 1'b0;
        ticks(4);
        rd(PA, v);
        chk("R8 drq restarts", v, 8'h50);
        ticks(1);
        rd(PA, v);
        chk("R8 at limit", v, 8'h52);
        wr(PA, 8'h80);
        rd(PA, v);
        chk("R7 ato cleared", v, 8'h50);
        wr(PA, 8'h00);
        ticks(10);
        rd(PA, v);
        chk("R8 disabled", v, 8'h50);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_miss();
        t_read();
        wr(PA, 8'h00);
        t_idle_ticks();
        t_motor();
        t_autowait();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule